// File: doc/BRIEF.md
# I2C I/O expander target with event-frozen status readback

This block is the bus-facing logic of a small I/O expander on a two-wire I2C bus. It answers one 7-bit target address. Three low address bits come from strap pins, and four upper bits are a build parameter. SCL and SDA are oversampled on the system clock. The target only ever pulls SDA low, through `sda_oe`; the bus pull-up supplies the high level. A write delivers two data bytes:

- The first byte is a control byte that sets the readback mode, a threshold-select output and a six-bit DAC code.
- The second byte drives eight parallel output pins.

A read returns one status byte. It holds two comparator flags and six sampled digital signals; the analog comparators and DAC sit outside and appear here as plain inputs and register outputs.

There are two readback modes:

- **Immediate mode:** the status byte is captured at the acknowledge of the read address.
- **Event mode:** a rising edge on comparator B freezes a snapshot of all status inputs. The next read returns that snapshot even if the inputs have moved since. The acknowledge of that read releases the freeze, so the next edge can be caught.

Control and status pins are plain levels. There is no streaming interface at the edge.

Top module: `i2c_event_expander`

## Requirements
- R1: The address byte is {ADDR_HI (default 4'b0101), addr_strap[2:0], dir}, MSB first, with dir 1 for read and 0 for write. On a match the target pulls SDA low for the 9th SCL clock (acknowledge). `sda_oe` changes only while SCL is low.
- R2: On an address mismatch the target never asserts `sda_oe` and changes no output until the next START.
- R3: The first byte of a write is acknowledged and, at its acknowledge, sets `latch_mode` = bit 7, `thr_sel` = bit 6 and `dac_code` = bits 5:0.
- R4: The second byte of a write is acknowledged and, at its acknowledge, sets `out_pins[i]` = bit i.
- R5: A third or later byte of a write is not acknowledged, and it leaves all outputs unchanged.
- R6: A read returns one byte, MSB first, driven on SDA while SCL is high. Bit 7 is cmp_a, bit 6 is cmp_b and bits 5:0 are sig_in[5:0]. With `latch_mode` 0 these values are captured at the acknowledge of the read address. The target releases SDA after the 8th data bit.
- R7: With `latch_mode` 1, a rising edge of cmp_b freezes {cmp_a, cmp_b, sig_in}. A following read returns the frozen value regardless of later input changes. Further cmp_b edges are ignored while frozen.
- R8: The acknowledge of a read address releases the freeze. Without a new cmp_b edge, the next read returns the values present at its own address acknowledge. A new edge freezes again.
- R9: A START in the middle of a byte aborts it, and the partial byte has no effect. A STOP returns the target to idle.
- R10: After reset `out_pins`, `dac_code`, `thr_sel`, `latch_mode` and `sda_oe` are 0 and nothing is frozen.
- R11: With `latch_mode` 0, cmp_b edges do not freeze; reads return the acknowledge-time values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_strap | input | 3 | Low three address bits from strap pins |
| cmp_a | input | 1 | Comparator A result |
| cmp_b | input | 1 | Comparator B result, also the freeze event source |
| sig_in | input | 6 | Sampled status signals |
| out_pins | output | 8 | Parallel output pins |
| dac_code | output | 6 | DAC code register |
| thr_sel | output | 1 | Threshold select register |
| latch_mode | output | 1 | Readback mode, 1 for event freeze |

## Verification
Every bus line change reaches the protocol logic two clocks later, through the synchronizers, and is acted on the clock after that. So `sda_oe`, the control outputs and the pins change three clocks after the SCL falling edge that opens an acknowledge. A cmp_b rising edge freezes the snapshot three clocks after it arrives. The bench holds each bus level for 20 clocks and waits ten clocks after any status input change. Its reference model updates expected outputs at the moment it drives the SCL fall, and it compares outputs on every clock only once eight clocks have passed since the last line change. Read and acknowledge bits are sampled late in the SCL high phase.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
  localparam int STRAP_W = 3;
  localparam int ADDR_W  = 7;
  localparam int HI_W    = ADDR_W - STRAP_W;
  localparam int NUM_SIG = 6;
  localparam int DAC_W   = 6;
  localparam int BYTE_W  = 8;
  localparam int MAX_WR  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD
  } st_t;

  typedef struct packed {
    logic             latch_mode;
    logic             thr_sel;
    logic [DAC_W-1:0] dac;
  } ctrl_t;
endpackage

// File: rtl/i2cx_sync.sv
module i2cx_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cx_bus_front.sv
module i2cx_bus_front (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] lines;
  logic       scl_q, sda_q;

  i2cx_sync #(.W(2), .STAGES(2), .RST(2'b11)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({scl_i, sda_i}),
    .q    (lines)
  );

  assign scl_s = lines[1];
  assign sda_s = lines[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cx_status_latch.sv
module i2cx_status_latch
  import i2cx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmp_a,
  input  logic               cmp_b,
  input  logic [NUM_SIG-1:0] sig_in,
  input  logic               latch_mode,
  input  logic               load,
  output logic [BYTE_W-1:0]  rd_byte,
  output logic               frozen,
  output logic [BYTE_W-1:0]  snap
);
  logic [BYTE_W-1:0] live;
  logic              b_q;
  logic              b_rise;

  i2cx_sync #(.W(BYTE_W), .STAGES(2), .RST('0)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({cmp_a, cmp_b, sig_in}),
    .q    (live)
  );

  assign b_rise = live[BYTE_W-2] & ~b_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_q    <= 1'b0;
      frozen <= 1'b0;
      snap   <= '0;
    end else begin
      b_q <= live[BYTE_W-2];
      if (load) begin
        frozen <= 1'b0;
      end else if (b_rise && latch_mode && !frozen) begin
        frozen <= 1'b1;
        snap   <= live;
      end
    end
  end

  assign rd_byte = (latch_mode && frozen) ? snap : live;
endmodule

// File: rtl/i2cx_target_fsm.sv
module i2cx_target_fsm
  import i2cx_pkg::*;
#(
  parameter logic [HI_W-1:0] ADDR_HI = 4'b0101
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic               sda_s,
  input  logic [STRAP_W-1:0] addr_strap,
  input  logic [BYTE_W-1:0]  rd_byte,
  output logic               sda_oe,
  output ctrl_t              ctrl,
  output logic [BYTE_W-1:0]  pins,
  output logic               rd_load,
  output logic               ctrl_we,
  output logic               pins_we,
  output st_t                state
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam int IDX_W = $clog2(MAX_WR + 1);

  logic [BYTE_W-1:0] sh, tx;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic              full, rw;
  logic              addr_hit, byte_end;

  assign addr_hit = (sh[BYTE_W-1:1] == {ADDR_HI, addr_strap});
  assign byte_end = scl_fall && full;
  assign rd_load  = (state == ST_ADDR) && byte_end && addr_hit && sh[0];
  assign ctrl_we  = (state == ST_WR) && byte_end && (idx == IDX_W'(0));
  assign pins_we  = (state == ST_WR) && byte_end && (idx == IDX_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
      ctrl   <= '0;
      pins   <= '0;
      sh     <= '0;
      tx     <= '0;
      cnt    <= '0;
      idx    <= '0;
      full   <= 1'b0;
      rw     <= 1'b0;
    end else begin
      if (ctrl_we) ctrl <= ctrl_t'(sh);
      if (pins_we) pins <= sh;
      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        idx    <= '0;
        full   <= 1'b0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        full   <= 1'b0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + CNT_W'(1);
              if (cnt == CNT_W'(BYTE_W - 1)) full <= 1'b1;
            end else if (byte_end) begin
              full <= 1'b0;
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  sda_oe <= 1'b1;
                  rw     <= sh[0];
                  state  <= ST_ADDR_ACK;
                  if (sh[0]) tx <= rd_byte;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (idx < IDX_W'(MAX_WR)) begin
                sda_oe <= 1'b1;
                idx    <= idx + IDX_W'(1);
                state  <= ST_WR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                sda_oe <= ~tx[BYTE_W-1];
                state  <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_WR;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt == CNT_W'(BYTE_W - 1)) begin
                sda_oe <= 1'b0;
                state  <= ST_IDLE;
              end else begin
                cnt    <= cnt + CNT_W'(1);
                tx     <= {tx[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx[BYTE_W-2];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_event_expander.sv
module i2c_event_expander
  import i2cx_pkg::*;
#(
  parameter logic [HI_W-1:0] ADDR_HI = 4'b0101
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] addr_strap,
  input  logic               cmp_a,
  input  logic               cmp_b,
  input  logic [NUM_SIG-1:0] sig_in,
  output logic [BYTE_W-1:0]  out_pins,
  output logic [DAC_W-1:0]   dac_code,
  output logic               thr_sel,
  output logic               latch_mode
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              rd_load, ctrl_we, pins_we, frozen;
  logic [BYTE_W-1:0] rd_byte, snap;
  ctrl_t             ctrl;
  st_t               state;

  i2cx_bus_front u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2cx_status_latch u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_a     (cmp_a),
    .cmp_b     (cmp_b),
    .sig_in    (sig_in),
    .latch_mode(ctrl.latch_mode),
    .load      (rd_load),
    .rd_byte   (rd_byte),
    .frozen    (frozen),
    .snap      (snap)
  );

  i2cx_target_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s),
    .addr_strap(addr_strap),
    .rd_byte   (rd_byte),
    .sda_oe    (sda_oe),
    .ctrl      (ctrl),
    .pins      (out_pins),
    .rd_load   (rd_load),
    .ctrl_we   (ctrl_we),
    .pins_we   (pins_we),
    .state     (state)
  );

  assign latch_mode = ctrl.latch_mode;
  assign thr_sel    = ctrl.thr_sel;
  assign dac_code   = ctrl.dac;
endmodule

// File: rtl/i2cx_checker.sv
module i2cx_checker
  import i2cx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic              sda_oe,
  input logic [BYTE_W-1:0] out_pins,
  input logic [BYTE_W-1:0] ctrl_bits,
  input logic              pins_we,
  input logic              ctrl_we,
  input logic              frozen,
  input logic [BYTE_W-1:0] snap,
  input logic              latch_mode,
  input logic              rd_load,
  input st_t               state
);
  // R1: the SDA drive changes only while SCL is low, except when forced off by START or STOP
  assert_sda_moves_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

  // R2: a target that has gone idle keeps SDA released
  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && $past(state) == ST_IDLE) |-> !sda_oe);

  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(ctrl_bits));

  assert_pins_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_we |=> $stable(out_pins));

  assert_snap_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && $past(frozen)) |-> $stable(snap));

  assert_load_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> !frozen);

  assert_freeze_needs_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen) |-> $past(latch_mode));
endmodule

bind i2c_event_expander i2cx_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe),
  .out_pins  (out_pins),
  .ctrl_bits (ctrl),
  .pins_we   (pins_we),
  .ctrl_we   (ctrl_we),
  .frozen    (frozen),
  .snap      (snap),
  .latch_mode(latch_mode),
  .rd_load   (rd_load),
  .state     (state)
);

// File: tb/i2c_event_expander_tb.sv
module i2c_event_expander_tb;
  localparam logic [3:0] HI = 4'b0101;
  localparam int H = 20;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_line;
  logic [2:0] strap = 3'b010;
  logic       cmp_a = 1'b0, cmp_b = 1'b0;
  logic [5:0] sig = 6'd0;
  logic       sda_oe, thr_sel, latch_mode;
  logic [7:0] out_pins;
  logic [5:0] dac_code;

  assign sda_line = sda_m & ~sda_oe;

  i2c_event_expander u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_strap(strap), .cmp_a(cmp_a), .cmp_b(cmp_b), .sig_in(sig),
    .out_pins(out_pins), .dac_code(dac_code), .thr_sel(thr_sel), .latch_mode(latch_mode)
  );

  int cyc = 0, settle_until = 1000000, total = 0, bad = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0] e_pins = 8'h00;
  logic       e_latch = 1'b0, e_thr = 1'b0, e_oe = 1'b0;
  logic [5:0] e_dac = 6'd0;
  logic       m_frozen = 1'b0;
  logic [7:0] m_snap = 8'h00;
  logic [7:0] rd_exp;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      if (bad < 40) $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, WD_LIMIT);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // per-clock comparison against the model once lines have settled
  always @(negedge clk) begin
    if (rst_n && !done && cyc >= settle_until) begin
      check(out_pins == e_pins, "R4 pins", out_pins, e_pins);
      check({latch_mode, thr_sel, dac_code} == {e_latch, e_thr, e_dac}, "R3 control",
            {latch_mode, thr_sel, dac_code}, {e_latch, e_thr, e_dac});
      check(sda_oe == e_oe, "R1 sda drive", sda_oe, e_oe);
    end
  end

  task automatic set_lines(input logic c, input logic d, input logic oe);
    @(posedge clk); #1;
    scl_m = c; sda_m = d; e_oe = oe;
    settle_until = cyc + 8;
  endtask

  task automatic hold();
    repeat (H) @(posedge clk);
  endtask

  task automatic step(input logic c, input logic d, input logic oe);
    set_lines(c, d, oe);
    hold();
  endtask

  task automatic start_cond();
    step(1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic stop_cond();
    step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0);
  endtask

  function automatic logic [7:0] take_read();
    logic [7:0] r;
    r = (e_latch && m_frozen) ? m_snap : {cmp_a, cmp_b, sig};
    m_frozen = 1'b0;
    return r;
  endfunction

  // kind: 0 none, 1 control byte, 2 pin byte, 3 read address
  task automatic send_byte(input logic [7:0] b, input bit ack, input int kind, input string req);
    for (int i = 7; i >= 0; i--) begin
      step(1'b0, b[i], 1'b0);
      step(1'b1, b[i], 1'b0);
    end
    set_lines(1'b0, 1'b1, ack);
    if (ack) begin
      if (kind == 1) {e_latch, e_thr, e_dac} = b;
      if (kind == 2) e_pins = b;
      if (kind == 3) rd_exp = take_read();
    end
    hold();
    set_lines(1'b1, 1'b1, ack);
    repeat (H - 2) @(posedge clk);
    @(negedge clk);
    check((sda_line == 1'b0) == ack, req, sda_line, !ack);
    @(posedge clk);
  endtask

  task automatic write_txn(input logic [2:0] a, input logic [7:0] c, input logic [7:0] p, input bit hit);
    start_cond();
    send_byte({HI, a, 1'b0}, hit, 0, hit ? "R1 write address ack" : "R2 mismatch nack");
    send_byte(c, hit, hit ? 1 : 0, hit ? "R3 control ack" : "R2 ignored byte");
    send_byte(p, hit, hit ? 2 : 0, hit ? "R4 pin ack" : "R2 ignored byte");
    stop_cond();
  endtask

  task automatic read_txn(input string req);
    logic [7:0] got;
    start_cond();
    send_byte({HI, strap, 1'b1}, 1'b1, 3, "R1 read address ack");
    for (int i = 7; i >= 0; i--) begin
      set_lines(1'b0, 1'b1, ~rd_exp[i]);
      hold();
      set_lines(1'b1, 1'b1, ~rd_exp[i]);
      repeat (H - 2) @(posedge clk);
      @(negedge clk);
      got[i] = sda_line;
      @(posedge clk);
    end
    step(1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    stop_cond();
    check(got == rd_exp, req, got, rd_exp);
  endtask

  task automatic set_status(input logic a, input logic b, input logic [5:0] s);
    @(posedge clk); #1;
    if (!cmp_b && b && e_latch && !m_frozen) begin
      m_frozen = 1'b1;
      m_snap = {a, b, s};
    end
    cmp_a = a; cmp_b = b; sig = s;
    repeat (10) @(posedge clk);
  endtask

  initial begin
    repeat (10) @(posedge clk);
    @(negedge clk);
    check({out_pins, dac_code, thr_sel, latch_mode, sda_oe} == 17'd0, "R10 outputs in reset",
          {out_pins, dac_code, thr_sel, latch_mode, sda_oe}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    settle_until = cyc + 4;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check({out_pins, dac_code, thr_sel, latch_mode, sda_oe} == 17'd0, "R10 outputs after reset",
          {out_pins, dac_code, thr_sel, latch_mode, sda_oe}, 0);

    // R3 R4 basic write
    write_txn(strap, 8'b0110_1011, 8'hA5, 1'b1);
    check(out_pins == 8'hA5, "R4 pins after write", out_pins, 8'hA5);
    check({latch_mode, thr_sel, dac_code} == 8'h6B, "R3 control after write",
          {latch_mode, thr_sel, dac_code}, 8'h6B);

    // R6 immediate-mode reads
    set_status(1'b1, 1'b0, 6'h15);
    read_txn("R6 read format a=1 b=0 sig=15");
    set_status(1'b0, 1'b0, 6'h2C);
    read_txn("R6 read follows live inputs");

    // R11 edges ignored in mode 0
    set_status(1'b0, 1'b1, 6'h11);
    set_status(1'b1, 1'b0, 6'h07);
    read_txn("R11 no freeze in immediate mode");

    // R7 event mode
    write_txn(strap, 8'b1100_0101, 8'h3C, 1'b1);
    set_status(1'b0, 1'b0, 6'h2A);
    set_status(1'b0, 1'b1, 6'h2A);
    set_status(1'b1, 1'b0, 6'h01);
    set_status(1'b1, 1'b1, 6'h01);
    read_txn("R7 frozen value returned");
    // R8 release and re-arm
    read_txn("R8 released read is live");
    set_status(1'b1, 1'b0, 6'h0F);
    set_status(1'b0, 1'b1, 6'h10);
    set_status(1'b1, 1'b0, 6'h3F);
    read_txn("R8 re-armed freeze");

    // R2 mismatched address
    write_txn(strap ^ 3'b001, 8'hFF, 8'hFF, 1'b0);
    check(out_pins == 8'h3C, "R2 pins unchanged by mismatch", out_pins, 8'h3C);
    check({latch_mode, thr_sel, dac_code} == 8'hC5, "R2 control unchanged by mismatch",
          {latch_mode, thr_sel, dac_code}, 8'hC5);

    // R5 extra byte
    start_cond();
    send_byte({HI, strap, 1'b0}, 1'b1, 0, "R1 write address ack");
    send_byte(8'h12, 1'b1, 1, "R3 control ack");
    send_byte(8'h81, 1'b1, 2, "R4 pin ack");
    send_byte(8'hEE, 1'b0, 0, "R5 third byte nack");
    stop_cond();
    check(out_pins == 8'h81, "R5 pins after extra byte", out_pins, 8'h81);
    check({latch_mode, thr_sel, dac_code} == 8'h12, "R5 control after extra byte",
          {latch_mode, thr_sel, dac_code}, 8'h12);

    // R9 abort by repeated START
    start_cond();
    send_byte({HI, strap, 1'b0}, 1'b1, 0, "R1 write address ack");
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0, 1'b0);
      step(1'b1, 1'b0, 1'b0);
    end
    start_cond();
    stop_cond();
    check(out_pins == 8'h81, "R9 partial byte ignored pins", out_pins, 8'h81);
    check({latch_mode, thr_sel, dac_code} == 8'h12, "R9 partial byte ignored control",
          {latch_mode, thr_sel, dac_code}, 8'h12);
    write_txn(strap, 8'h3F, 8'h5A, 1'b1);
    check(out_pins == 8'h5A, "R9 write after abort", out_pins, 8'h5A);

    repeat (20) @(posedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule